// File: doc/BRIEF.md
# Byte-Framed Result Scan Streamer

This block holds 32-bit results from a compute core in a small internal queue and hands them to a host through a 13-bit scan data register. Each scan returns exactly one byte of the oldest result. The byte travels with a valid flag and a position marker. From these two fields the host can tell an empty queue from real data. It can also find the first byte of a result after it joins the stream part-way through, and it can discard a result whose bytes arrive out of order.

The core offers a result with a one-cycle push strobe. The scan side is driven by a capture strobe and a shift strobe that are synchronous to the block clock. These come from an external test access port controller. A capture loads the next framed byte into the scan register. Each shift moves one bit out on `tdo`, least significant bit first, and takes one bit from `tdi` into the top of the register. A result leaves the queue only when its last byte has been captured. Its bytes therefore always arrive consecutively and never mix with the bytes of another result.

Top module: `nonce_byte_streamer`

## Requirements
- R1: After reset `overflow` is 0, and a capture with no result pushed returns the 13-bit word 0.
- R2: A capture while the queue is empty loads all zeros. The valid flag is bit 12, so any word below 0x1000 means no data.
- R3: A capture while the queue holds a result loads a word with bit 12 = 1, bits 11:8 = position marker and bits 7:0 = one byte of the oldest result. Bytes go out least significant first: bits 7:0 of the result, then 15:8, then 23:16, then 31:24.
- R4: The markers for byte 0, 1, 2 and 3 are 4'b1111, 4'b0111, 4'b0011 and 4'b0001. Marker 4'b0001 marks the final byte.
- R5: A result is popped only when its final byte is captured. The capture after that returns the next result with marker 4'b1111. Results pushed while a result is part-way out do not interrupt it.
- R6: While `shiftDr` is high and `captureDr` is low, `tdo` shows bit 0 of the scan register. On each clock the register moves right by one and `tdi` enters bit 12. A capture takes priority over a shift in the same cycle.
- R7: The queue keeps DEPTH results (default 4) in arrival order.
- R8: A push while the queue is full is dropped, and `overflow` then goes to 1 and stays at 1 until reset.
- R9: Reset empties the queue, returns the byte position to byte 0 and clears `overflow`.
- R10: Shift cycles without a capture do not advance the byte position. The next capture returns the same byte that it would have returned without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | One-cycle strobe offering a result from the core |
| pushData | input | 32 | Result offered with `pushValid` |
| captureDr | input | 1 | Loads the next framed byte into the scan register |
| shiftDr | input | 1 | Shifts the scan register one bit toward `tdo` |
| tdi | input | 1 | Serial bit entering bit 12 on a shift |
| tdo | output | 1 | Bit 0 of the scan register |
| overflow | output | 1 | Sticky flag, set when a push is dropped on a full queue |

## Verification
The assertions assume that `captureDr`, `shiftDr` and `pushValid` are already synchronous to `clk`, with any clock-domain crossing from the scan clock done upstream. They also assume that reset is applied before the first strobe. The bench changes every input only at falling clock edges. Each capture is a single-cycle pulse, followed by a burst of shift cycles, and pushes never come faster than one per cycle. A reference queue in the bench predicts every framed word, including the dropped push, results pushed in the middle of another result, and shifting with no capture.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int RES_BYTES = 4;
  localparam int RES_W     = RES_BYTES * 8;
  localparam int POS_W     = $clog2(RES_BYTES);
  localparam int SCAN_W    = 1 + RES_BYTES + 8;

  typedef struct packed {
    logic             pushEn;
    logic             popEn;
    logic             loadWord;
    logic             shiftEn;
    logic             wordValid;
    logic [POS_W-1:0] bytePos;
  } strobe_t;
endpackage

// File: rtl/nbs_ctl.sv
module nbs_ctl
  import nbs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pushValid,
  input  logic    captureDr,
  input  logic    shiftDr,
  output strobe_t stb,
  output logic    overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(RES_BYTES - 1);

  logic [CNT_W-1:0] count;
  logic [POS_W-1:0] bytePtr;
  logic isFull, isEmpty;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);

  always_comb begin
    stb.pushEn    = pushValid && !isFull;
    stb.loadWord  = captureDr;
    stb.wordValid = !isEmpty;
    stb.popEn     = captureDr && !isEmpty && (bytePtr == LAST_POS);
    stb.shiftEn   = shiftDr && !captureDr;
    stb.bytePos   = bytePtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      bytePtr  <= '0;
      overflow <= 1'b0;
    end else begin
      count <= count + CNT_W'(stb.pushEn) - CNT_W'(stb.popEn);
      if (captureDr && !isEmpty)
        bytePtr <= (bytePtr == LAST_POS) ? '0 : bytePtr + 1'b1;
      if (pushValid && isFull)
        overflow <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);                                        // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && isFull) |=> overflow);                           // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));                                       // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !captureDr |=> $stable(bytePtr));                              // R10
  AST_POP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    stb.popEn |=> (bytePtr == '0));                                // R5
endmodule

// File: rtl/nbs_dp.sv
module nbs_dp
  import nbs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [RES_W-1:0] pushData,
  input  logic             tdi,
  output logic             tdo
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [RES_W-1:0]  store [DEPTH];
  logic [IDX_W-1:0]  wrIdx, rdIdx;
  logic [SCAN_W-1:0] scanReg;
  logic [SCAN_W-1:0] framed;
  logic [7:0]        byteSel;
  logic [RES_BYTES-1:0] marker;
  logic [RES_W-1:0]  head;

  assign head = store[rdIdx];

  always_comb begin
    byteSel = '0;
    for (int b = 0; b < RES_BYTES; b++)
      if (stb.bytePos == POS_W'(b)) byteSel = head[b*8 +: 8];
  end

  assign marker = {RES_BYTES{1'b1}} >> stb.bytePos;
  assign framed = stb.wordValid ? {1'b1, marker, byteSel} : '0;

  always_ff @(posedge clk) begin
    if (stb.pushEn) store[wrIdx] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      scanReg <= '0;
    end else begin
      if (stb.pushEn) wrIdx <= (wrIdx == LAST_IDX) ? '0 : wrIdx + 1'b1;
      if (stb.popEn)  rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + 1'b1;
      if (stb.loadWord)     scanReg <= framed;
      else if (stb.shiftEn) scanReg <= {tdi, scanReg[SCAN_W-1:1]};
    end
  end

  assign tdo = scanReg[0];

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadWord && !stb.wordValid) |=> (scanReg == '0));         // R2
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |=> (scanReg[SCAN_W-2:0] == $past(scanReg[SCAN_W-1:1]))); // R6
  AST_VALID_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadWord && stb.wordValid) |=>
      (scanReg[SCAN_W-1] && scanReg[8] && scanReg[8 +: RES_BYTES] != '0)); // R4
endmodule

// File: rtl/nonce_byte_streamer.sv
module nonce_byte_streamer
  import nbs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushValid,
  input  logic [31:0] pushData,
  input  logic        captureDr,
  input  logic        shiftDr,
  input  logic        tdi,
  output logic        tdo,
  output logic        overflow
);
  strobe_t stb;

  nbs_ctl #(.DEPTH(DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .captureDr(captureDr),
    .shiftDr(shiftDr), .stb(stb), .overflow(overflow)
  );

  nbs_dp #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .pushData(pushData),
    .tdi(tdi), .tdo(tdo)
  );
endmodule

// File: tb/tb_nonce_byte_streamer.sv
module tb_nonce_byte_streamer;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [31:0] pushData = '0;
  logic captureDr = 1'b0;
  logic shiftDr = 1'b0;
  logic tdi = 1'b0;
  logic tdo, overflow;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  int expPos = 0;
  logic expOvf = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nonce_byte_streamer #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .captureDr(captureDr), .shiftDr(shiftDr), .tdi(tdi), .tdo(tdo),
    .overflow(overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    expQ.delete(); expPos = 0; expOvf = 1'b0;
  endtask

  // driver: pushes a result and records the expectation
  task automatic pushResult(input logic [31:0] d);
    @(negedge clk); pushValid = 1'b1; pushData = d;
    @(negedge clk); pushValid = 1'b0;
    if (expQ.size() < DEPTH) expQ.push_back(d);
    else expOvf = 1'b1;
  endtask

  // shift 13 bits out while shifting pat in
  task automatic shiftWord(input logic [12:0] pat, output logic [12:0] got);
    shiftDr = 1'b1;
    for (int i = 0; i < 13; i++) begin
      got[i] = tdo;
      tdi = pat[i];
      @(negedge clk);
    end
    shiftDr = 1'b0;
  endtask

  // monitor: one scan, compared against the reference queue head
  task automatic scanCheck(input string req);
    logic [12:0] got, exp;
    @(negedge clk); captureDr = 1'b1;
    @(negedge clk); captureDr = 1'b0;
    shiftWord(13'h0, got);
    if (expQ.size() == 0) exp = '0;
    else begin
      exp = {1'b1, 4'hF >> expPos, 8'(expQ[0] >> (8 * expPos))};
      if (expPos == 3) begin void'(expQ.pop_front()); expPos = 0; end
      else expPos++;
    end
    check(req, 32'(got), 32'(exp));
  endtask

  initial begin
    logic [12:0] junk, back;
    doReset();
    check("R1 overflow after reset", 32'(overflow), 32'(0));
    scanCheck("R1 R2 empty scan after reset");

    pushResult(32'hA1B2C3D4);
    for (int k = 0; k < 4; k++) scanCheck("R3 R4 byte order and markers");
    scanCheck("R2 empty after drain");

    pushResult(32'h11223344);
    pushResult(32'h55667788);
    scanCheck("R5 first result byte0");
    scanCheck("R5 first result byte1");
    pushResult(32'h99AABBCC);
    scanCheck("R5 no interleave byte2");
    // shifting without capture must not consume a byte
    shiftWord(13'h1555, junk);
    shiftWord(13'h0AAA, junk);
    scanCheck("R10 byte3 after idle shifts");
    for (int k = 0; k < 8; k++) scanCheck("R5 R7 following results in order");
    scanCheck("R2 empty again");

    // tdi shifts through the register
    shiftWord(13'h1A5C, junk);
    shiftWord(13'h0000, back);
    check("R6 tdi path", 32'(back), 32'h1A5C);

    // capture wins over shift in the same cycle
    pushResult(32'hDEADBEEF);
    @(negedge clk); captureDr = 1'b1; shiftDr = 1'b1;
    @(negedge clk); captureDr = 1'b0; shiftDr = 1'b0;
    shiftWord(13'h0, back);
    check("R6 capture priority", 32'(back), {19'h0, 1'b1, 4'hF, 8'hEF});
    expPos = 1;
    for (int k = 0; k < 3; k++) scanCheck("R4 remaining bytes");

    // overflow
    for (int k = 0; k < DEPTH + 1; k++) pushResult(32'h01020304 * (k + 1));
    check("R8 overflow set", 32'(overflow), 32'(expOvf));
    for (int k = 0; k < 4 * DEPTH; k++) scanCheck("R7 R8 kept results");
    scanCheck("R8 dropped result absent");
    check("R8 overflow sticky", 32'(overflow), 32'(1));

    // reset mid-result
    pushResult(32'hCAFEF00D);
    scanCheck("R9 pre-reset byte0");
    scanCheck("R9 pre-reset byte1");
    doReset();
    check("R9 overflow cleared", 32'(overflow), 32'(0));
    scanCheck("R9 queue empty after reset");
    pushResult(32'h76543210);
    scanCheck("R9 restart at byte0");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule